// File: doc/BRIEF.md
# DRAM Rank Low-Power State Controller

This block tracks the power state of one DRAM rank and decides, cycle by cycle, when the rank drops into active power-down, precharge power-down or self-refresh, and when it comes back. A scheduler tells it when commands are scheduled and completed. It also supplies the rank's read and write queue occupancy, the current bus direction, the number of open banks, read-response and last-precharge completions, refresh start and end, and wake requests.

The block returns the power state, a low-power flag and one-cycle strobes for power-down entry and exit and for self-refresh entry and exit. It also returns, for every bank, the earliest cycle at which a column, precharge or activate command may next be issued. These bank bounds are pushed out by the exit delay whenever the rank wakes.

A pending-work counter gates every low-power entry. The counter rises on each scheduled burst, precharge or refresh and falls when that work completes. A counter of cycles spent in any low-power state is kept for power accounting.

Top module: `rank_pwr_ctl`

## Requirements
- R1: After reset the state is idle, all strobes, the low-power flag and the error flag are 0, the idle-cycle count is 0 and every bank bound is 0.
- R2: The state code on `pwr_state_o` is idle=0, refresh=1, self-refresh=2, precharge power-down=3, active=4, active power-down=5. Idle moves to active when the open-bank count is nonzero. The low-power flag is 1 exactly in codes 2, 3 and 5.
- R3: The pending-work counter adds one for each scheduled pulse and removes one for each completion pulse. A completion pulse that arrives while the counter is zero does not decrement the counter and sets a sticky error flag.
- R4: Entry into low power outside refresh is allowed only if the counter, after this cycle's pulses, is zero and the queue of the current direction is empty. The read queue is used when `bus_wr_i`=0 and the write queue when it is 1. The queue of the other direction is ignored.
- R5: A read-response pulse with entry allowed moves active to active power-down, or idle to precharge power-down, and raises `pd_enter_o` for one cycle.
- R6: In the active state, a last-precharge pulse with the open-bank count at zero leads to precharge power-down (with `pd_enter_o`) if entry is allowed, and to idle otherwise.
- R7: A refresh starts only from idle or precharge power-down. At refresh end with the current-direction queue empty, the rank goes to self-refresh (with `sr_enter_o`) if the refresh began in precharge power-down. If the refresh began in idle, it goes to precharge power-down (with `pd_enter_o`). With that queue non-empty, the rank goes to idle.
- R8: A wake request moves active power-down to active and precharge power-down to idle, and raises `pd_exit_o`. In every other state a wake request is ignored.
- R9: Self-refresh is left for idle (with `sr_exit_o`) when the read queue is non-empty, or when the direction is write and the write queue is non-empty. Otherwise it is held.
- R10: The time base counts cycles from 0 in the first cycle after reset. On a wake in cycle t, each bank bound becomes the larger of its current value and t+T_XP for a power-down exit, or t+T_XS for a self-refresh exit. A per-bank set input loads a bound with `set_time_i`.
- R11: The idle-cycle count rises by one for every cycle spent in a low-power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_sched_i | input | 1 | A burst, precharge or refresh was scheduled |
| evt_done_i | input | 1 | A scheduled event completed |
| rd_entries_i | input | Q_W | Queued reads for the rank |
| wr_entries_i | input | Q_W | Queued writes for the rank |
| bus_wr_i | input | 1 | Current bus direction, 1 = write |
| open_banks_i | input | BANK_W | Number of open banks |
| rd_resp_i | input | 1 | Read response completed |
| pre_done_i | input | 1 | A precharge completed |
| ref_start_i | input | 1 | Begin refresh |
| ref_end_i | input | 1 | Refresh finished |
| wake_i | input | 1 | Wake request for a command |
| col_set_i | input | NUM_BANKS | Load column bound per bank |
| pre_set_i | input | NUM_BANKS | Load precharge bound per bank |
| act_set_i | input | NUM_BANKS | Load activate bound per bank |
| set_time_i | input | T_W | Value for bound loads |
| pwr_state_o | output | 3 | Power state code |
| low_pwr_o | output | 1 | Rank is in a low-power state |
| pd_enter_o | output | 1 | Power-down entry strobe |
| pd_exit_o | output | 1 | Power-down exit strobe |
| sr_enter_o | output | 1 | Self-refresh entry strobe |
| sr_exit_o | output | 1 | Self-refresh exit strobe |
| evt_err_o | output | 1 | Sticky counter underflow error |
| idle_cycles_o | output | IDLE_W | Cycles spent in low power |
| col_at_o | output | NUM_BANKS*T_W | Earliest column cycle per bank |
| pre_at_o | output | NUM_BANKS*T_W | Earliest precharge cycle per bank |
| act_at_o | output | NUM_BANKS*T_W | Earliest activate cycle per bank |

## Verification
The bench builds the block with two banks, T_XP=3 and T_XS=7, so the two exit delays give distinct bound values. It also keeps one bank loaded with a far-future bound, which shows that the maximum keeps a larger existing value. A 16-bit time base stays far from wrap-around within the short run. That lets absolute cycle numbers be compared after each wake. The sequence walks every entry path: read response from active and from idle, last precharge, and refresh end into both self-refresh and power-down. It includes a non-empty queue in the unused direction and a completion on an empty counter, and it checks that the counter does not wrap after that completion.

// File: rtl/rank_pwr_pkg.sv
package rank_pwr_pkg;
    typedef enum logic [2:0] {
        PS_IDLE = 3'd0,
        PS_REF  = 3'd1,
        PS_SREF = 3'd2,
        PS_PPD  = 3'd3,
        PS_ACT  = 3'd4,
        PS_APD  = 3'd5
    } pwr_state_e;

    function automatic logic is_low_power(pwr_state_e s);
        return (s == PS_SREF) || (s == PS_PPD) || (s == PS_APD);
    endfunction
endpackage

// File: rtl/rank_evt_cnt.sv
module rank_evt_cnt #(
    parameter int CNT_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sched_i,
    input  logic done_i,
    output logic zero_next_o,
    output logic err_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             err;
    } cnt_s;

    cnt_s q, d;
    logic under;

    always_comb begin
        d     = q;
        under = done_i && (q.cnt == '0);
        if (under) d.err = 1'b1;
        case ({sched_i, done_i && !under})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign zero_next_o = (d.cnt == '0);
    assign err_o       = q.err;

    // R3: a completion on an empty counter is flagged
    a_r3_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && q.cnt == '0) |=> q.err);
    // R3: the error flag never clears
    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |=> q.err);
    // R3: an empty counter never wraps on a lone completion
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !sched_i && q.cnt == '0) |=> (q.cnt == '0));
endmodule

// File: rtl/rank_bank_guard.sv
module rank_bank_guard #(
    parameter int T_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           col_set_i,
    input  logic           pre_set_i,
    input  logic           act_set_i,
    input  logic [T_W-1:0] set_time_i,
    input  logic           wake_i,
    input  logic [T_W-1:0] bound_i,
    output logic [T_W-1:0] col_o,
    output logic [T_W-1:0] pre_o,
    output logic [T_W-1:0] act_o
);
    typedef struct packed {
        logic [T_W-1:0] col;
        logic [T_W-1:0] pre;
        logic [T_W-1:0] act;
    } bound_s;

    bound_s q, d;

    function automatic logic [T_W-1:0] bump(logic [T_W-1:0] cur, logic w, logic [T_W-1:0] b);
        return (w && b > cur) ? b : cur;
    endfunction

    always_comb begin
        d     = q;
        d.col = bump(col_set_i ? set_time_i : q.col, wake_i, bound_i);
        d.pre = bump(pre_set_i ? set_time_i : q.pre, wake_i, bound_i);
        d.act = bump(act_set_i ? set_time_i : q.act, wake_i, bound_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign col_o = q.col;
    assign pre_o = q.pre;
    assign act_o = q.act;

    // R10: after a wake every bound is at least the wake bound
    a_r10_wake_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wake_i |=> (q.col >= $past(bound_i) && q.pre >= $past(bound_i) && q.act >= $past(bound_i)));
    // R10: without wake or load a column bound holds
    a_r10_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_i && !col_set_i) |=> $stable(q.col));
endmodule

// File: rtl/rank_pwr_ctl.sv
module rank_pwr_ctl #(
    parameter int NUM_BANKS = 4,
    parameter int Q_W       = 5,
    parameter int CNT_W     = 6,
    parameter int T_W       = 16,
    parameter int IDLE_W    = 32,
    parameter int T_XP      = 3,
    parameter int T_XS      = 10,
    localparam int BANK_W   = $clog2(NUM_BANKS + 1),
    localparam int BT_W     = NUM_BANKS * T_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_sched_i,
    input  logic              evt_done_i,
    input  logic [Q_W-1:0]    rd_entries_i,
    input  logic [Q_W-1:0]    wr_entries_i,
    input  logic              bus_wr_i,
    input  logic [BANK_W-1:0] open_banks_i,
    input  logic              rd_resp_i,
    input  logic              pre_done_i,
    input  logic              ref_start_i,
    input  logic              ref_end_i,
    input  logic              wake_i,
    input  logic [NUM_BANKS-1:0] col_set_i,
    input  logic [NUM_BANKS-1:0] pre_set_i,
    input  logic [NUM_BANKS-1:0] act_set_i,
    input  logic [T_W-1:0]    set_time_i,
    output logic [2:0]        pwr_state_o,
    output logic              low_pwr_o,
    output logic              pd_enter_o,
    output logic              pd_exit_o,
    output logic              sr_enter_o,
    output logic              sr_exit_o,
    output logic              evt_err_o,
    output logic [IDLE_W-1:0] idle_cycles_o,
    output logic [BT_W-1:0]   col_at_o,
    output logic [BT_W-1:0]   pre_at_o,
    output logic [BT_W-1:0]   act_at_o
);
    import rank_pwr_pkg::*;

    localparam logic [T_W-1:0] XP_DLY = T_W'(T_XP);
    localparam logic [T_W-1:0] XS_DLY = T_W'(T_XS);

    typedef struct packed {
        pwr_state_e        state;
        logic              came_ppd;
        logic              pd_en;
        logic              pd_ex;
        logic              sr_en;
        logic              sr_ex;
        logic [IDLE_W-1:0] idle;
        logic [T_W-1:0]    now;
    } ctl_s;

    ctl_s q, d;
    logic zero_next, q_empty, entry_ok, force_sx, wake_go;
    logic [T_W-1:0] bound;

    rank_evt_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .sched_i(evt_sched_i), .done_i(evt_done_i),
        .zero_next_o(zero_next), .err_o(evt_err_o)
    );

    assign q_empty  = bus_wr_i ? (wr_entries_i == '0) : (rd_entries_i == '0);
    assign entry_ok = zero_next && q_empty;
    assign force_sx = (rd_entries_i != '0) || (bus_wr_i && wr_entries_i != '0);

    always_comb begin
        d       = q;
        d.now   = q.now + 1'b1;
        d.pd_en = 1'b0;
        d.pd_ex = 1'b0;
        d.sr_en = 1'b0;
        d.sr_ex = 1'b0;
        if (is_low_power(q.state)) d.idle = q.idle + 1'b1;
        case (q.state)
            PS_IDLE: begin
                if (ref_start_i) begin
                    d.state = PS_REF; d.came_ppd = 1'b0;
                end else if (rd_resp_i && entry_ok) begin
                    d.state = PS_PPD; d.pd_en = 1'b1;
                end else if (open_banks_i != '0) begin
                    d.state = PS_ACT;
                end
            end
            PS_ACT: begin
                if (rd_resp_i && entry_ok) begin
                    d.state = PS_APD; d.pd_en = 1'b1;
                end else if (pre_done_i && open_banks_i == '0) begin
                    if (entry_ok) begin
                        d.state = PS_PPD; d.pd_en = 1'b1;
                    end else begin
                        d.state = PS_IDLE;
                    end
                end
            end
            PS_APD: if (wake_i) begin
                d.state = PS_ACT; d.pd_ex = 1'b1;
            end
            PS_PPD: begin
                if (ref_start_i) begin
                    d.state = PS_REF; d.came_ppd = 1'b1;
                end else if (wake_i) begin
                    d.state = PS_IDLE; d.pd_ex = 1'b1;
                end
            end
            PS_REF: if (ref_end_i) begin
                if (q_empty && q.came_ppd) begin
                    d.state = PS_SREF; d.sr_en = 1'b1;
                end else if (q_empty) begin
                    d.state = PS_PPD; d.pd_en = 1'b1;
                end else begin
                    d.state = PS_IDLE;
                end
            end
            PS_SREF: if (force_sx) begin
                d.state = PS_IDLE; d.sr_ex = 1'b1;
            end
            default: d.state = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{state: PS_IDLE, default: '0};
        else        q <= d;
    end

    assign wake_go = d.pd_ex || d.sr_ex;
    assign bound   = q.now + ((q.state == PS_SREF) ? XS_DLY : XP_DLY);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rank_bank_guard #(.T_W(T_W)) u_guard (
            .clk(clk), .rst_n(rst_n),
            .col_set_i(col_set_i[b]), .pre_set_i(pre_set_i[b]), .act_set_i(act_set_i[b]),
            .set_time_i(set_time_i), .wake_i(wake_go), .bound_i(bound),
            .col_o(col_at_o[b*T_W +: T_W]), .pre_o(pre_at_o[b*T_W +: T_W]),
            .act_o(act_at_o[b*T_W +: T_W])
        );
    end

    assign pwr_state_o   = q.state;
    assign low_pwr_o     = is_low_power(q.state);
    assign pd_enter_o    = q.pd_en;
    assign pd_exit_o     = q.pd_ex;
    assign sr_enter_o    = q.sr_en;
    assign sr_exit_o     = q.sr_ex;
    assign idle_cycles_o = q.idle;

    // R8: active power-down only returns to active
    a_r8_apd_to_act: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.state) == PS_APD && q.state != PS_APD) |-> q.state == PS_ACT);
    // R9: self-refresh only returns to idle
    a_r9_sref_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.state) == PS_SREF && q.state != PS_SREF) |-> q.state == PS_IDLE);
    // R7: refresh is entered only from idle or precharge power-down
    a_r7_ref_source: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.state) != PS_REF && q.state == PS_REF) |->
        ($past(q.state) == PS_IDLE || $past(q.state) == PS_PPD));
    // R5: a power-down entry strobe comes with a fresh power-down state
    a_r5_entry_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        pd_enter_o |-> ((q.state == PS_PPD || q.state == PS_APD) && !$past(low_pwr_o)));
    // R8: an exit strobe follows a low-power cycle
    a_r8_exit_follows_lp: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_exit_o || sr_exit_o) |-> ($past(low_pwr_o) && !low_pwr_o));
    // R11: the idle count rises in each low-power cycle
    a_r11_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
        low_pwr_o |=> idle_cycles_o == $past(idle_cycles_o) + 1'b1);
    // R2: at most one strobe at a time
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pd_enter_o, pd_exit_o, sr_enter_o, sr_exit_o}));
endmodule

// File: tb/rank_pwr_ctl_tb_top.sv
`timescale 1ns/1ps
module rank_pwr_ctl_tb_top;
    localparam int NB = 2;
    localparam int TW = 16;
    localparam int XP = 3;
    localparam int XS = 7;
    localparam logic [2:0] S_IDLE = 3'd0, S_REF = 3'd1, S_SREF = 3'd2,
                           S_PPD = 3'd3, S_ACT = 3'd4, S_APD = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_sched, evt_done, bus_wr, rd_resp, pre_done, ref_start, ref_end, wake;
    logic [4:0] rd_ent, wr_ent;
    logic [1:0] open_banks;
    logic [NB-1:0] col_set, pre_set, act_set;
    logic [TW-1:0] set_time;
    logic [2:0] pwr_state;
    logic low_pwr, pd_en, pd_ex, sr_en, sr_ex, err;
    logic [31:0] idle_cyc;
    logic [NB*TW-1:0] col_at, pre_at, act_at;

    always #2 clk = ~clk;

    rank_pwr_ctl #(.NUM_BANKS(NB), .T_W(TW), .T_XP(XP), .T_XS(XS)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_sched_i(evt_sched), .evt_done_i(evt_done),
        .rd_entries_i(rd_ent), .wr_entries_i(wr_ent), .bus_wr_i(bus_wr),
        .open_banks_i(open_banks), .rd_resp_i(rd_resp), .pre_done_i(pre_done),
        .ref_start_i(ref_start), .ref_end_i(ref_end), .wake_i(wake),
        .col_set_i(col_set), .pre_set_i(pre_set), .act_set_i(act_set), .set_time_i(set_time),
        .pwr_state_o(pwr_state), .low_pwr_o(low_pwr), .pd_enter_o(pd_en), .pd_exit_o(pd_ex),
        .sr_enter_o(sr_en), .sr_exit_o(sr_ex), .evt_err_o(err), .idle_cycles_o(idle_cyc),
        .col_at_o(col_at), .pre_at_o(pre_at), .act_at_o(act_at)
    );

    int n_chk = 0;
    int n_fail = 0;
    int tb_cyc = 0;
    bit finished = 0;

    typedef struct {
        int         req;
        logic [2:0] st;
        logic [3:0] strb;
    } exp_t;
    exp_t sb_q[$];

    always @(posedge clk) begin
        if (!rst_n) tb_cyc <= 0;
        else        tb_cyc <= tb_cyc + 1;
    end

    task automatic chk(input int req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pops one expectation per cycle, away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.req, "state", pwr_state, e.st);
            chk(e.req, "strobes", {pd_en, pd_ex, sr_en, sr_ex}, e.strb);
            chk(2, "low_pwr", low_pwr, (e.st == S_SREF || e.st == S_PPD || e.st == S_APD));
        end
    end

    // driver: inputs are set before the call; push the expectation after the edge, clear pulses
    task automatic step(input int req, input logic [2:0] st, input logic [3:0] strb);
        @(posedge clk);
        #1;
        sb_q.push_back('{req: req, st: st, strb: strb});
        evt_sched = 0; evt_done = 0; rd_resp = 0; pre_done = 0;
        ref_start = 0; ref_end = 0; wake = 0;
        col_set = '0; pre_set = '0; act_set = '0;
    endtask

    function automatic longint bnk(input logic [NB*TW-1:0] v, input int b);
        return v[b*TW +: TW];
    endfunction

    initial begin
        #40000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int w;
        evt_sched = 0; evt_done = 0; bus_wr = 0; rd_resp = 0; pre_done = 0;
        ref_start = 0; ref_end = 0; wake = 0; rd_ent = 0; wr_ent = 0; open_banks = 0;
        col_set = '0; pre_set = '0; act_set = '0; set_time = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(1, "state", pwr_state, S_IDLE);
        chk(1, "strobes", {pd_en, pd_ex, sr_en, sr_ex, low_pwr, err}, 0);
        chk(1, "idle", idle_cyc, 0);
        chk(1, "bounds", col_at | pre_at | act_at, 0);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R2 idle to active on open bank
        open_banks = 1;                              step(2, S_ACT, 4'b0000);
        evt_sched = 1;                               step(3, S_ACT, 4'b0000);
        // R4 read queue non-empty blocks entry
        rd_ent = 1; rd_resp = 1; evt_done = 1;       step(4, S_ACT, 4'b0000);
        rd_ent = 0; evt_sched = 1;                   step(3, S_ACT, 4'b0000);
        // R5 active to active power-down
        rd_resp = 1; evt_done = 1;                   step(5, S_APD, 4'b1000);
        step(5, S_APD, 4'b0000);
        step(11, S_APD, 4'b0000);
        chk(11, "idle after two cycles", idle_cyc, 2);
        col_set = 2'b01; set_time = 500;             step(10, S_APD, 4'b0000);
        chk(10, "bank0 col load", bnk(col_at, 0), 500);
        // R8 wake from active power-down, R10 bounds
        w = tb_cyc; wake = 1;                        step(8, S_ACT, 4'b0100);
        chk(10, "bank0 col keeps larger", bnk(col_at, 0), 500);
        chk(10, "bank1 col", bnk(col_at, 1), w + XP);
        chk(10, "bank0 pre", bnk(pre_at, 0), w + XP);
        chk(10, "bank1 act", bnk(act_at, 1), w + XP);
        chk(11, "idle counts wake cycle", idle_cyc, 4);
        step(11, S_ACT, 4'b0000);
        chk(11, "idle holds when active", idle_cyc, 4);
        // R4 write direction ignores read queue; R6 last precharge
        bus_wr = 1; rd_ent = 3; evt_sched = 1;       step(4, S_ACT, 4'b0000);
        open_banks = 0; pre_done = 1; evt_done = 1;  step(6, S_PPD, 4'b1000);
        // R7 refresh from precharge power-down ends in self-refresh
        ref_start = 1; evt_sched = 1;                step(7, S_REF, 4'b0000);
        ref_end = 1; evt_done = 1; rd_ent = 0;       step(7, S_SREF, 4'b0010);
        // R8 wake ignored in self-refresh; R9 writes queued in read direction do not force exit
        bus_wr = 0; wr_ent = 2; wake = 1;            step(8, S_SREF, 4'b0000);
        step(9, S_SREF, 4'b0000);
        // R9 forced exit in write direction
        w = tb_cyc; bus_wr = 1;                      step(9, S_IDLE, 4'b0001);
        chk(10, "bank1 col after sref exit", bnk(col_at, 1), w + XS);
        chk(10, "bank0 act after sref exit", bnk(act_at, 0), w + XS);
        chk(10, "bank0 col still larger", bnk(col_at, 0), 500);
        // R7 refresh end with queued writes goes idle
        evt_sched = 1; ref_start = 1;                step(7, S_REF, 4'b0000);
        ref_end = 1; evt_done = 1;                   step(7, S_IDLE, 4'b0000);
        // R7 refresh from idle with empty queue goes to precharge power-down
        wr_ent = 0; evt_sched = 1; ref_start = 1;    step(7, S_REF, 4'b0000);
        ref_end = 1; evt_done = 1;                   step(7, S_PPD, 4'b1000);
        wake = 1;                                    step(8, S_IDLE, 4'b0100);
        // R6 last precharge with queued writes goes idle
        open_banks = 1;                              step(2, S_ACT, 4'b0000);
        evt_sched = 1; wr_ent = 1;                   step(6, S_ACT, 4'b0000);
        open_banks = 0; pre_done = 1; evt_done = 1;  step(6, S_IDLE, 4'b0000);
        // R3 completion on empty counter
        chk(3, "error before", err, 0);
        evt_done = 1;                                step(3, S_IDLE, 4'b0000);
        chk(3, "error set", err, 1);
        step(3, S_IDLE, 4'b0000);
        chk(3, "error sticky", err, 1);
        // R3 counter did not wrap: entry still allowed; R5 idle to precharge power-down
        wr_ent = 0; rd_resp = 1;                     step(5, S_PPD, 4'b1000);
        wake = 1;                                    step(8, S_IDLE, 4'b0100);
        step(8, S_IDLE, 4'b0000);
        @(negedge clk);
        #1;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule